// File: doc/BRIEF.md
# Low-Resolution Composite Video Generator

This block turns a small monochrome bitmap into a composite video signal for a 50 Hz television display. It drives two digital lines, a sync bit and a pixel bit. An external resistor divider sums these two lines into three analog levels: sync tip, black and white. The block keeps its own horizontal and vertical position counters. It fetches bitmap bytes through a synchronous read port with one cycle of latency and shifts each byte out one pixel at a time. Outside the visible window the pixel line is held low.

The picture is 48 pixels wide and 28 bitmap rows tall. Each bitmap row is 6 bytes and is drawn on 10 consecutive scanlines, so a frame of 312 lines holds 280 visible lines, centred vertically. All timing is counted in clocks of a 12 MHz reference, with one pixel every 12 clocks and a line every 768 clocks. Every size and interval is a parameter. A one-clock pulse at the start of each frame lets a processor schedule work during the blanked lines.

Top module: `cvid_gen`

## Requirements
- R1: The output pair {sync_o, pix_o} only takes the values 00 (sync tip), 10 (black) and 11 (white); pix_o is never 1 while sync_o is 0.
- R2: On every line except the vertical-sync lines, sync_o is 0 for the first HSYNC_CLKS clocks of the LINE_CLKS-clock line and 1 for the rest.
- R3: On the first VSYNC_LINES lines of a frame, sync_o is 0 for the whole line except its final HSYNC_CLKS clocks, where it is 1.
- R4: On an active line, pix_o is 0 before clock ACT_START and after clock ACT_START + 8·BYTES_PER_ROW·CLK_PER_PIX of the line; in between, each pixel lasts CLK_PER_PIX clocks.
- R5: The bytes of a bitmap row are shown left to right in ascending address order, and within a byte bit 0 is shown first and bit 7 last.
- R6: The active lines begin at line VSYNC_LINES + (FRAME_LINES − VSYNC_LINES − ROWS·LINES_PER_ROW)/2. Bitmap row r (byte addresses r·BYTES_PER_ROW onward) is shown on LINES_PER_ROW consecutive lines before the next row is shown.
- R7: On every line outside the active rows, pix_o stays 0.
- R8: rd_en_o is high for exactly one clock, namely the clock before the first clock of each byte. While it is high, rd_addr_o carries that byte's address. On any other clock rd_en_o is low.
- R9: frame_o is high for one clock at the first clock of line 0 of every frame, and low otherwise.
- R10: While rst is high, sync_o, pix_o, rd_en_o and frame_o are 0. After rst falls, the first clock is clock 0 of line 0. Every output reflects the position of the previous clock (one register of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_o | output | 1 | Frame-buffer read strobe |
| rd_addr_o | output | AW | Frame-buffer byte address |
| rd_data_i | input | 8 | Frame-buffer data, valid one clock after the strobe |
| sync_o | output | 1 | Sync drive bit (0 = sync tip) |
| pix_o | output | 1 | Pixel drive bit (1 = white) |
| frame_o | output | 1 | One-clock frame start pulse |

## Verification
The bench uses a reduced configuration: 3 clocks per pixel, 2 bytes per row, 3 rows of 2 lines each, and 12 lines per frame. It sweeps two full frames clock by clock against a model computed arithmetically. The bitmap holds single-bit bytes 0x01 and 0x80, so a reversed bit order or a pixel off by one position shows up. It also holds mixed bytes whose values all differ, so a wrong byte address, a wrong row advance or a wrong line repeat reads wrong data. Every sync edge, read strobe and address is compared on every clock. This separates vertical-sync lines from normal lines and blanking lines from active ones, and it catches fetches issued a clock early or late.

// File: rtl/cvid_pkg.sv
package cvid_pkg;
  typedef enum logic [1:0] {
    LN_VSYNC  = 2'd0,
    LN_BLANK  = 2'd1,
    LN_ACTIVE = 2'd2
  } line_kind_t;
endpackage

// File: rtl/cvid_htimer.sv
// Horizontal position: clock within line, clock within pixel, pixel slot.
module cvid_htimer #(
  parameter int LINE_CLKS   = 768,
  parameter int CLK_PER_PIX = 12,
  parameter int HCW         = 10,
  parameter int SCW         = 4,
  parameter int PXW         = 7
) (
  input  logic           clk,
  input  logic           rst,
  output logic [HCW-1:0] hc,
  output logic [SCW-1:0] sc,
  output logic [PXW-1:0] px,
  output logic           line_end
);
  assign line_end = (int'(hc) == LINE_CLKS - 1);

  always_ff @(posedge clk) begin
    if (rst || line_end) begin
      hc <= '0;
      sc <= '0;
      px <= '0;
    end else begin
      hc <= hc + 1'b1;
      if (int'(sc) == CLK_PER_PIX - 1) begin
        sc <= '0;
        px <= px + 1'b1;
      end else begin
        sc <= sc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cvid_vtimer.sv
// Vertical position: line class and bitmap row currently displayed.
module cvid_vtimer
  import cvid_pkg::*;
#(
  parameter int FRAME_LINES   = 312,
  parameter int VSYNC_LINES   = 3,
  parameter int ACT_LINE0     = 17,
  parameter int ACT_LINES     = 280,
  parameter int LINES_PER_ROW = 10,
  parameter int RW            = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  output line_kind_t    kind,
  output logic [RW-1:0] row,
  output logic          top_line
);
  localparam int VCW = $clog2(FRAME_LINES);
  localparam int LRW = $clog2(LINES_PER_ROW + 1);

  logic [VCW-1:0] vc;
  logic [LRW-1:0] lr;

  always_comb begin
    if (int'(vc) < VSYNC_LINES)
      kind = LN_VSYNC;
    else if (int'(vc) >= ACT_LINE0 && int'(vc) < ACT_LINE0 + ACT_LINES)
      kind = LN_ACTIVE;
    else
      kind = LN_BLANK;
  end

  assign top_line = (vc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      vc  <= '0;
      lr  <= '0;
      row <= '0;
    end else if (line_end) begin
      if (int'(vc) == FRAME_LINES - 1) begin
        vc  <= '0;
        lr  <= '0;
        row <= '0;
      end else begin
        vc <= vc + 1'b1;
        if (kind == LN_ACTIVE) begin
          if (int'(lr) == LINES_PER_ROW - 1) begin
            lr  <= '0;
            row <= row + 1'b1;
          end else begin
            lr <= lr + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cvid_serializer.sv
// Byte-to-pixel shifter, least significant bit first.
module cvid_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         cur_bit
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)        sh <= '0;
    else if (load)  sh <= din;
    else if (shift) sh <= {1'b0, sh[W-1:1]};
  end

  // The byte is shown in its arrival clock straight from the port.
  assign cur_bit = load ? din[0] : sh[0];
endmodule

// File: rtl/cvid_gen.sv
module cvid_gen
  import cvid_pkg::*;
#(
  parameter int CLK_PER_PIX   = 12,
  parameter int LINE_CLKS     = 768,
  parameter int HSYNC_CLKS    = 56,
  parameter int ACT_START     = 144,
  parameter int BYTES_PER_ROW = 6,
  parameter int ROWS          = 28,
  parameter int LINES_PER_ROW = 10,
  parameter int FRAME_LINES   = 312,
  parameter int VSYNC_LINES   = 3,
  localparam int FB_BYTES     = ROWS * BYTES_PER_ROW,
  localparam int AW           = $clog2(FB_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          sync_o,
  output logic          pix_o,
  output logic          frame_o
);
  localparam int PIX       = BYTES_PER_ROW * 8;
  localparam int PX0       = ACT_START / CLK_PER_PIX;
  localparam int ACT_LINES = ROWS * LINES_PER_ROW;
  localparam int ACT_LINE0 = VSYNC_LINES + (FRAME_LINES - VSYNC_LINES - ACT_LINES) / 2;
  localparam int HCW       = $clog2(LINE_CLKS);
  localparam int SCW       = $clog2(CLK_PER_PIX);
  localparam int PXW       = $clog2(LINE_CLKS / CLK_PER_PIX + 2);
  localparam int RW        = $clog2(ROWS + 1);

  logic [HCW-1:0] hc;
  logic [SCW-1:0] sc;
  logic [PXW-1:0] px;
  logic           line_end;
  line_kind_t     kind;
  logic [RW-1:0]  row;
  logic           top_line;

  cvid_htimer #(
    .LINE_CLKS(LINE_CLKS), .CLK_PER_PIX(CLK_PER_PIX),
    .HCW(HCW), .SCW(SCW), .PXW(PXW)
  ) u_h (
    .clk(clk), .rst(rst), .hc(hc), .sc(sc), .px(px), .line_end(line_end)
  );

  cvid_vtimer #(
    .FRAME_LINES(FRAME_LINES), .VSYNC_LINES(VSYNC_LINES),
    .ACT_LINE0(ACT_LINE0), .ACT_LINES(ACT_LINES),
    .LINES_PER_ROW(LINES_PER_ROW), .RW(RW)
  ) u_v (
    .clk(clk), .rst(rst), .line_end(line_end),
    .kind(kind), .row(row), .top_line(top_line)
  );

  // Position inside the visible window, for this pixel and the next one.
  int   pos, nxt;
  logic active, in_h, in_n, load, shift, req, cur_bit, sync_n;
  logic [AW-1:0] addr_n;

  always_comb begin
    pos    = int'(px) - PX0;
    nxt    = pos + 1;
    active = (kind == LN_ACTIVE);
    in_h   = (pos >= 0) && (pos < PIX);
    in_n   = (nxt >= 0) && (nxt < PIX);
    load   = active && in_h && (pos[2:0] == 3'd0) && (sc == '0);
    shift  = active && in_h && (int'(sc) == CLK_PER_PIX - 1);
    // Strobe one clock early so the registered strobe lands one clock ahead.
    req    = active && in_n && (nxt[2:0] == 3'd0) && (int'(sc) == CLK_PER_PIX - 2);
    addr_n = AW'(int'(row) * BYTES_PER_ROW + nxt / 8);
    if (kind == LN_VSYNC)
      sync_n = (int'(hc) >= LINE_CLKS - HSYNC_CLKS);
    else
      sync_n = (int'(hc) >= HSYNC_CLKS);
  end

  cvid_serializer #(.W(8)) u_ser (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .din(rd_data_i), .cur_bit(cur_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_o    <= 1'b0;
      pix_o     <= 1'b0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      frame_o   <= 1'b0;
    end else begin
      sync_o  <= sync_n;
      pix_o   <= active && in_h && cur_bit;
      rd_en_o <= req;
      if (req) rd_addr_o <= addr_n;
      frame_o <= top_line && (hc == '0);
    end
  end
endmodule

// File: rtl/cvid_gen_chk.sv
module cvid_gen_chk #(
  parameter int FB_BYTES = 168,
  parameter int AW       = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_o,
  input logic          pix_o,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          frame_o
);
  a_r1_no_white_in_sync: assert property (@(posedge clk) disable iff (rst)
    !sync_o |-> !pix_o);

  a_r4_black_after_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> !pix_o);

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |=> !rd_en_o);

  a_r8_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |-> (int'(rd_addr_o) < FB_BYTES));

  a_r9_frame_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_o |=> !frame_o);

  a_r3_frame_in_vsync: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> !sync_o);
endmodule

bind cvid_gen cvid_gen_chk #(.FB_BYTES(FB_BYTES), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .sync_o(sync_o), .pix_o(pix_o),
  .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .frame_o(frame_o)
);

// File: tb/tb_cvid_gen.sv
module tb_cvid_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CPP   = 3;
  localparam int LINE  = 80;
  localparam int HS    = 5;
  localparam int AS    = 15;
  localparam int BPR   = 2;
  localparam int ROWS  = 3;
  localparam int LPR   = 2;
  localparam int FRAME = 12;
  localparam int VS    = 2;
  localparam int PIX   = BPR * 8;
  localparam int AL0   = VS + (FRAME - VS - ROWS * LPR) / 2;
  localparam int AW    = $clog2(ROWS * BPR);
  localparam int NCYC  = 2 * LINE * FRAME + 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en_o, sync_o, pix_o, frame_o;
  logic [AW-1:0] rd_addr_o;
  logic [7:0] rd_data_i = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvid_gen #(
    .CLK_PER_PIX(CPP), .LINE_CLKS(LINE), .HSYNC_CLKS(HS), .ACT_START(AS),
    .BYTES_PER_ROW(BPR), .ROWS(ROWS), .LINES_PER_ROW(LPR),
    .FRAME_LINES(FRAME), .VSYNC_LINES(VS)
  ) dut (
    .clk(clk), .rst(rst), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .sync_o(sync_o), .pix_o(pix_o), .frame_o(frame_o)
  );

  function automatic logic [7:0] fb(int i);
    if (i == 0) return 8'h01;
    if (i == 1) return 8'h80;
    return 8'((i * 91 + 60) % 256);
  endfunction

  // Synchronous read port with one clock of latency; holds when idle.
  always @(posedge clk) if (rd_en_o) rd_data_i <= fb(int'(rd_addr_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp, input int q);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at pos %0d: actual %0d expected %0d", req, q, act, exp);
    end
  endtask

  initial begin : wdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset values
    chk(sync_o == 1'b0, "R10 sync", int'(sync_o), 0, -1);
    chk(pix_o == 1'b0, "R10 pix", int'(pix_o), 0, -1);
    chk(rd_en_o == 1'b0, "R10 rd_en", int'(rd_en_o), 0, -1);
    chk(frame_o == 1'b0, "R10 frame", int'(frame_o), 0, -1);
    rst = 1'b0;
    for (int n = 1; n <= NCYC; n++) begin
      @(posedge clk);
      @(negedge clk);
      begin
        int  q, h, v, row, j, exp_addr;
        bit  vs, act_v, in_h, e_sync, e_pix, e_rd, e_fr;
        q     = n - 1;
        h     = q % LINE;
        v     = (q / LINE) % FRAME;
        vs    = (v < VS);
        act_v = (v >= AL0) && (v < AL0 + ROWS * LPR);
        row   = (v - AL0) / LPR;
        in_h  = (h >= AS) && (h < AS + PIX * CPP);
        e_sync = vs ? (h >= LINE - HS) : (h >= HS);
        e_pix = 1'b0;
        if (act_v && in_h) begin
          j = (h - AS) / CPP;
          e_pix = fb(row * BPR + j / 8)[j % 8];
        end
        e_rd = 1'b0;
        exp_addr = 0;
        for (int k = 0; k < BPR; k++)
          if (act_v && (h == AS + k * 8 * CPP - 2)) begin
            e_rd = 1'b1;
            exp_addr = row * BPR + k;
          end
        e_fr = (q % (LINE * FRAME) == 0);

        chk(!(sync_o == 1'b0 && pix_o == 1'b1), "R1 level code", {sync_o, pix_o}, 2, q);
        chk(sync_o == e_sync, vs ? "R3 vsync" : "R2 hsync", int'(sync_o), int'(e_sync), q);
        chk(pix_o == e_pix, !act_v ? "R7 blank line" : (!in_h ? "R4 hblank" : "R5 pixel"),
            int'(pix_o), int'(e_pix), q);
        chk(rd_en_o == e_rd, "R8 strobe", int'(rd_en_o), int'(e_rd), q);
        if (e_rd)
          chk(int'(rd_addr_o) == exp_addr, "R6 row address", int'(rd_addr_o), exp_addr, q);
        chk(frame_o == e_fr, "R9 frame", int'(frame_o), int'(e_fr), q);
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule